// File: doc/BRIEF.md
# Parallel EEPROM page-write engine

This block is a clocked, synthesizable model of the write path of a byte-wide parallel EEPROM. The host drives active-low chip-select, output-enable and write-strobe pins, a 15-bit address and a data byte. Each accepted write strobe drops one byte into a page holding register. A load timer watches the gaps between strobes. Once the strobes stop for long enough, a self-timed commit copies the loaded bytes into an internal array. While the commit runs, the host learns its progress by reading two status bits. When the commit ends, the holding register empties itself.

The bidirectional data bus is split into an input byte, an output byte and an output-drive flag. The pad logic merges them. All analog delays are expressed as clock-cycle parameters:
- `MIN_PULSE`: the shortest strobe that counts as a write.
- `LOAD_CYC`: the length of the load window.
- `WC_CYC`: the duration of the commit.
- `INIT_CYC`: the write lockout after reset.

The array holds `ARRAY_PAGES` pages. The lowest page-number bits pick the page, so higher page numbers alias onto the same rows. The array keeps its contents across reset.

Top module: `pgw_eeprom`

## Requirements
- R1: For `INIT_CYC` cycles after reset, all write strobes are ignored. A byte strobed in that period never reaches the array.
- R2: A read cycle drives `dout_en` high and returns the array byte at the address. A read cycle is `ce_n`=0, `oe_n`=0, `we_n`=1. With `ce_n`=1, `dout_en` is low. `dout_en` is low after reset.
- R3: A write cycle lasting fewer than `MIN_PULSE` clock cycles loads nothing and starts no commit. A cycle of exactly `MIN_PULSE` cycles is accepted. A write cycle is `ce_n`=0, `oe_n`=1, `we_n`=0.
- R4: The commit starts exactly `LOAD_CYC` idle cycles after the last write-strobe activity. Any strobe activity restarts the count. Reads before that point still return the old array data.
- R5: The page number is address bits 14..6. The first byte of a load window fixes it. A later byte in the same window with a different page number is dropped.
- R6: During the commit, every read returns a status byte. Bit 7 of the status byte is the complement of bit 7 of the last byte loaded. Bits 5..0 are zero.
- R7: During the commit, status bit 6 inverts at the end of every read cycle, so two successive reads differ in bit 6.
- R8: The commit lasts `WC_CYC` cycles. After it, every loaded byte is in the array at the offset given by address bits 5..0, and the holding register is empty.
- R9: Write strobes during the commit are ignored. They change no array byte and start no further commit.
- R10: The write may be timed by `ce_n` with `we_n` held low, as well as by `we_n` with `ce_n` held low.
- R11: Bytes of the page that were not loaded keep their old array values. A byte loaded twice in one window commits its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 15 | Byte address: page in bits 14..6, offset in bits 5..0 |
| din | input | 8 | Data byte from the host |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | High while the block drives the data bus |

## Verification
The bench aims at the timing edges of the load window:
- A strobe one cycle shorter than the minimum must leave the array alone and must not start a commit. A design that counted it would overwrite the byte or show a status byte instead of data.
- A read just after the last strobe must still see old data. A design with too short a window would show status there.

It also checks that the holding register empties after a commit. It does this by starting the next window on a different page. A design that kept the old page lock would silently drop that byte.

Writes issued during a busy commit, and a byte aimed at a foreign page, must both leave their target addresses unchanged. Polling must show the complemented bit 7 and an alternating bit 6. A design that polled from the wrong byte, or never toggled, would fail the status checks.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_INHIBIT,
        ST_IDLE,
        ST_LOADING,
        ST_COMMIT
    } pgw_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pgw_wbyte_t;

    // Status byte shown while a commit is running.
    function automatic logic [DATA_W-1:0] status_byte(input logic last_msb, input logic tog);
        return {~last_msb, tog, {(DATA_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/pgw_strobe.sv
module pgw_strobe
    import pgw_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_act,
    output logic              accept,
    output pgw_wbyte_t        held,
    output logic              rd_act,
    output logic              rd_end
);
    localparam int LEN_W = $clog2(MIN_PULSE + 1);

    logic [LEN_W-1:0] len_q;
    logic             wr_q;
    logic             rd_q;

    // Either ce_n or we_n may frame the write; the later falling one opens it.
    assign wr_act = ~ce_n & oe_n & ~we_n;
    assign rd_act = ~ce_n & ~oe_n & we_n;
    assign accept = wr_q & ~wr_act & (len_q >= LEN_W'(MIN_PULSE));
    assign rd_end = rd_q & ~rd_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            wr_q  <= 1'b0;
            rd_q  <= 1'b0;
            held  <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act) begin
                held <= '{addr: addr, data: din};
                if (len_q < LEN_W'(MIN_PULSE)) len_q <= len_q + 1'b1;
            end else begin
                len_q <= '0;
            end
        end
    end
endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES  = 64,
    parameter int ARRAY_PAGES = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load_en,
    input  pgw_wbyte_t                      ld,
    input  logic                            clear,
    input  logic [$clog2(PAGE_BYTES)-1:0]   copy_off,
    output logic [PAGE_BYTES-1:0]           mask,
    output logic [$clog2(ARRAY_PAGES)-1:0]  sel,
    output logic                            last_msb,
    output logic [DATA_W-1:0]               copy_byte
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int SEL_W = $clog2(ARRAY_PAGES);

    logic [PG_W-1:0]                  page_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slot;
    logic [OFF_W-1:0]                 ld_off;
    logic [PG_W-1:0]                  ld_page;
    logic                             take;

    assign ld_off  = ld.addr[OFF_W-1:0];
    assign ld_page = ld.addr[ADDR_W-1:OFF_W];
    // First byte of a window sets the page; later bytes must match it.
    assign take    = load_en & ((mask == '0) | (ld_page == page_q));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            page_q   <= '0;
            last_msb <= 1'b0;
        end else if (take) begin
            page_q   <= ld_page;
            last_msb <= ld.data[DATA_W-1];
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                mask[g] <= 1'b0;
            end else if (take && ld_off == OFF_W'(g)) begin
                mask[g] <= 1'b1;
                slot[g] <= ld.data;
            end
        end
    end

    assign sel       = page_q[SEL_W-1:0];
    assign copy_byte = slot[copy_off];
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int LOAD_CYC   = 20,
    parameter int WC_CYC     = 80,
    parameter int INIT_CYC   = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_act,
    input  logic                          accept,
    output pgw_state_t                    state,
    output logic                          copy_en,
    output logic [$clog2(PAGE_BYTES)-1:0] copy_off,
    output logic                          commit_end
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int CMAX  = (INIT_CYC > WC_CYC) ? INIT_CYC : WC_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam int TMR_W = $clog2(LOAD_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [TMR_W-1:0] tmr;

    assign copy_en    = (state == ST_COMMIT) && (cnt < CNT_W'(PAGE_BYTES));
    assign copy_off   = cnt[OFF_W-1:0];
    assign commit_end = (state == ST_COMMIT) && (cnt == CNT_W'(WC_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INHIBIT;
            cnt   <= '0;
            tmr   <= '0;
        end else begin
            // Load timer: held at zero by any strobe activity, counts otherwise.
            if (wr_act)                      tmr <= '0;
            else if (tmr < TMR_W'(LOAD_CYC)) tmr <= tmr + 1'b1;

            unique case (state)
                ST_INHIBIT: begin
                    if (cnt == CNT_W'(INIT_CYC - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_IDLE: if (accept) state <= ST_LOADING;
                ST_LOADING: begin
                    if (!wr_act && tmr == TMR_W'(LOAD_CYC - 1)) begin
                        state <= ST_COMMIT;
                        cnt   <= '0;
                    end
                end
                ST_COMMIT: begin
                    if (commit_end) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgw_eeprom.sv
module pgw_eeprom
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES  = 64,   // power of two
    parameter int ARRAY_PAGES = 4,    // power of two, at least 2
    parameter int MIN_PULSE   = 3,
    parameter int LOAD_CYC    = 20,   // at least 2
    parameter int WC_CYC      = 80,   // larger than PAGE_BYTES
    parameter int INIT_CYC    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int OFF_W       = $clog2(PAGE_BYTES);
    localparam int SEL_W       = $clog2(ARRAY_PAGES);
    localparam int IDX_W       = SEL_W + OFF_W;
    localparam int ARRAY_BYTES = ARRAY_PAGES * PAGE_BYTES;

    logic                  wr_act, accept, rd_act, rd_end;
    pgw_wbyte_t            held;
    pgw_state_t            state;
    logic                  copy_en, commit_end, load_en, busy, tog;
    logic [OFF_W-1:0]      copy_off;
    logic [PAGE_BYTES-1:0] mask;
    logic [SEL_W-1:0]      sel;
    logic                  last_msb;
    logic [DATA_W-1:0]     copy_byte;
    logic [IDX_W-1:0]      rd_idx;
    logic [DATA_W-1:0]     mem [ARRAY_BYTES];

    pgw_strobe #(.MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_act(wr_act), .accept(accept),
        .held(held), .rd_act(rd_act), .rd_end(rd_end)
    );

    pgw_seq #(
        .PAGE_BYTES(PAGE_BYTES), .LOAD_CYC(LOAD_CYC),
        .WC_CYC(WC_CYC), .INIT_CYC(INIT_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .wr_act(wr_act), .accept(accept),
        .state(state), .copy_en(copy_en), .copy_off(copy_off),
        .commit_end(commit_end)
    );

    assign load_en = accept && (state == ST_IDLE || state == ST_LOADING);
    assign busy    = (state == ST_COMMIT);

    pgw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .ARRAY_PAGES(ARRAY_PAGES)) u_buf (
        .clk(clk), .rst(rst), .load_en(load_en), .ld(held),
        .clear(commit_end), .copy_off(copy_off), .mask(mask),
        .sel(sel), .last_msb(last_msb), .copy_byte(copy_byte)
    );

    // One byte per cycle moves from the holding register to the array.
    always_ff @(posedge clk) begin
        if (copy_en && mask[copy_off]) mem[{sel, copy_off}] <= copy_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)                 tog <= 1'b0;
        else if (busy && rd_end) tog <= ~tog;
    end

    assign rd_idx  = {addr[OFF_W +: SEL_W], addr[OFF_W-1:0]};
    assign dout    = busy ? status_byte(last_msb, tog) : mem[rd_idx];
    assign dout_en = rd_act;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int MIN_PULSE  = 3,
    parameter int LOAD_CYC   = 20,
    parameter int WC_CYC     = 80
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_n,
    input  logic                  oe_n,
    input  logic                  we_n,
    input  logic                  busy,
    input  logic                  load_en,
    input  logic [PAGE_BYTES-1:0] mask,
    input  pgw_state_t            state
);
    localparam int RUN_W = $clog2(MIN_PULSE + 2);
    localparam int GAP_W = $clog2(LOAD_CYC + 2);
    localparam int BSY_W = $clog2(WC_CYC + 2);

    logic             strobe;
    logic [RUN_W-1:0] run;
    logic [GAP_W-1:0] gap;
    logic [BSY_W-1:0] bcnt;

    assign strobe = ~ce_n & oe_n & ~we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            gap  <= '0;
            bcnt <= '0;
        end else begin
            run  <= strobe ? ((run < RUN_W'(MIN_PULSE + 1)) ? run + 1'b1 : run) : '0;
            gap  <= strobe ? '0 : ((gap < GAP_W'(LOAD_CYC + 1)) ? gap + 1'b1 : gap);
            bcnt <= busy ? ((bcnt < BSY_W'(WC_CYC + 1)) ? bcnt + 1'b1 : bcnt) : '0;
        end
    end

    assert_inhibit_empty_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INHIBIT) |-> (mask == '0));

    assert_min_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (run >= RUN_W'(MIN_PULSE)));

    assert_load_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (gap == GAP_W'(LOAD_CYC)));

    assert_commit_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (bcnt == BSY_W'(WC_CYC)));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mask));
endmodule

bind pgw_eeprom pgw_checker #(
    .PAGE_BYTES(PAGE_BYTES), .MIN_PULSE(MIN_PULSE),
    .LOAD_CYC(LOAD_CYC), .WC_CYC(WC_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .load_en(load_en), .mask(mask), .state(state)
);

// File: tb/tb_pgw_eeprom.sv
module tb_pgw_eeprom;
    localparam int MIN_PULSE = 3;
    localparam int LOAD_CYC  = 20;
    localparam int WC_CYC    = 80;
    localparam int INIT_CYC  = 16;

    typedef struct packed {
        logic [14:0] a;
        logic [7:0]  d;
        logic [7:0]  e;
        logic        chk;
    } vec_t;

    // One load window on page 1; the page-3 byte must be dropped (R5),
    // 0x0045 is loaded twice (R11).
    localparam vec_t VECS [0:5] = '{
        '{15'h0040, 8'h11, 8'h11, 1'b1},
        '{15'h0041, 8'h22, 8'h22, 1'b1},
        '{15'h0045, 8'h33, 8'h55, 1'b1},
        '{15'h007F, 8'h80, 8'h80, 1'b1},
        '{15'h0045, 8'h55, 8'h55, 1'b1},
        '{15'h00C2, 8'h99, 8'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pgw_eeprom #(
        .MIN_PULSE(MIN_PULSE), .LOAD_CYC(LOAD_CYC),
        .WC_CYC(WC_CYC), .INIT_CYC(INIT_CYC)
    ) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_we(input logic [14:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        repeat (width) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wr_ce(input logic [14:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        addr = a; din = d; we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (width) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] v, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        v = dout; en = dout_en;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic poll(input logic [14:0] a, input logic [7:0] exp, output int n);
        logic [7:0] v;
        logic       en;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            rd(a, v, en);
            n++;
            if (v === exp) break;
        end
    endtask

    initial begin
        logic [7:0] v, v2;
        logic       en;
        int         n;

        do_reset();
        #1 check("R2 reset drive", {7'd0, dout_en}, 8'd0);
        repeat (INIT_CYC + 4) @(negedge clk);

        // Vector walk: one page window, then commit.
        for (int i = 0; i < 6; i++) begin
            wr_we(VECS[i].a, VECS[i].d, 4);
            repeat (2) @(negedge clk);
        end
        repeat (LOAD_CYC + 2) @(negedge clk);
        rd(15'h0045, v, en);
        check("R6 poll bit7", {7'd0, v[7]}, 8'd1);
        check("R6 low bits", {2'd0, v[5:0]}, 8'd0);
        rd(15'h0045, v2, en);
        check("R7 toggle", {7'd0, v2[6]}, {7'd0, ~v[6]});
        wr_we(15'h0041, 8'h77, 4);                 // R9: ignored while busy
        poll(15'h0045, 8'h55, n);
        check("R8 commit length", {7'd0, (n > 20 && n < 50)}, 8'd1);
        for (int i = 0; i < 6; i++) begin
            if (VECS[i].chk) begin
                rd(VECS[i].a, v, en);
                check($sformatf("R8 R11 R9 vector %0d", i), v, VECS[i].e);
            end
        end
        repeat (LOAD_CYC + 5) @(negedge clk);
        rd(15'h0041, v, en);
        check("R9 no stray commit", v, 8'h22);

        // Holding register must be empty: a new page is accepted.
        wr_we(15'h0083, 8'h3C, 4);
        poll(15'h0083, 8'h3C, n);
        check("R8 latches cleared", {7'd0, n < 200}, 8'd1);

        // Partial page and window boundary.
        wr_we(15'h0041, 8'hA5, 4);
        rd(15'h0041, v, en);
        check("R4 window still open", v, 8'h22);
        poll(15'h0041, 8'hA5, n);
        check("R11 partial commit", {7'd0, n < 200}, 8'd1);
        rd(15'h0040, v, en);  check("R11 kept 0040", v, 8'h11);
        rd(15'h0045, v, en);  check("R11 kept 0045", v, 8'h55);
        rd(15'h007F, v, en);  check("R11 kept 007F", v, 8'h80);

        // Foreign page byte dropped.
        wr_we(15'h0083, 8'hC3, 4);
        repeat (2) @(negedge clk);
        wr_we(15'h0040, 8'hEE, 4);
        poll(15'h0083, 8'hC3, n);
        check("R5 first byte kept", {7'd0, n < 200}, 8'd1);
        rd(15'h0040, v, en);
        check("R5 foreign dropped", v, 8'h11);

        // Chip-select timed write.
        wr_ce(15'h0010, 8'h6B, 4);
        poll(15'h0010, 8'h6B, n);
        check("R10 ce write", {7'd0, n < 200}, 8'd1);

        // Pulse width boundary.
        wr_we(15'h0010, 8'h00, MIN_PULSE - 1);
        repeat (LOAD_CYC + 10) @(negedge clk);
        rd(15'h0010, v, en);
        check("R3 short pulse", v, 8'h6B);
        check("R2 read drive", {7'd0, en}, 8'd1);
        wr_we(15'h0010, 8'h9D, MIN_PULSE);
        poll(15'h0010, 8'h9D, n);
        check("R3 min pulse", {7'd0, n < 200}, 8'd1);

        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #2 check("R2 deselected", {7'd0, dout_en}, 8'd0);
        @(negedge clk);
        oe_n = 1'b1;

        // Lockout after reset.
        do_reset();
        wr_we(15'h0010, 8'h44, 4);
        repeat (INIT_CYC + LOAD_CYC + WC_CYC + 10) @(negedge clk);
        rd(15'h0010, v, en);
        check("R1 inhibit", v, 8'h9D);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule